// File: doc/BRIEF.md
# Iterative Shift-Compare Unsigned Divider

This block divides one unsigned integer by another for the execute stage of a small processor. It takes a dividend and a divisor on a one-cycle start strobe and returns a quotient and a remainder. The quotient is built one bit per clock by a restoring shift-and-compare loop, which uses one comparator/subtractor and one shift register. Every divide takes the same number of cycles. Pipeline control can therefore stall for a fixed, known count and does not need to watch the operands.

A divide runs through four phases. First come two setup cycles: the divisor is checked for zero, then the working registers are loaded. Next come one iteration cycle per operand bit. Last comes one writeback cycle, in which the result is presented and `done_o` pulses. With the default 32-bit width, this gives 35 busy cycles.

The control pins are plain and there is no valid/ready stream. A start is taken only while `busy_o` is low. A start raised while busy is dropped and is not queued. The caller must watch `busy_o` before raising `start_i`, and it must take the result in the cycle that `done_o` is high or at any time before the next accepted start reaches writeback.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A start that is sampled high on a clock edge while `busy_o` is low is accepted. `busy_o` is then high for exactly 2 + WIDTH + 1 cycles (35 at the default), starting with the cycle after the accepting edge. This count does not depend on the operand values.
- R3: `done_o` is high for exactly one cycle per accepted divide, and that cycle is the last cycle in which `busy_o` is high.
- R4: For a nonzero divisor, `quotient_o` equals floor(dividend / divisor) and `remainder_o` equals dividend mod divisor, taken as unsigned WIDTH-bit values. Both are valid from the cycle in which `done_o` is high.
- R5: `quotient_o` and `remainder_o` keep their values from the `done_o` cycle until the writeback cycle of the next accepted divide.
- R6: A start raised while `busy_o` is high, including in the `done_o` cycle, is ignored. It changes neither the result nor the timing of the divide in progress.
- R7: With a divisor of 0, the quotient is all ones and the remainder equals the dividend. The latency is the same as for any other divide.
- R8: A start held high through the `done_o` cycle is accepted on the first edge at which `busy_o` is low, so two divides can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a divide with the present operands |
| dividend_i | input | WIDTH | Unsigned dividend, sampled on the accepting edge |
| divisor_i | input | WIDTH | Unsigned divisor, sampled on the accepting edge |
| busy_o | output | 1 | High while a divide is in progress |
| done_o | output | 1 | One-cycle pulse in the writeback cycle |
| quotient_o | output | WIDTH | Quotient of the last completed divide |
| remainder_o | output | WIDTH | Remainder of the last completed divide |

## Verification
The bench drives the design with a set of edge-case operands:
- The all-ones dividend with a divisor of 1. An off-by-one iteration count shows up here as a quotient shifted by one bit.
- A divisor larger than the dividend, which must give a quotient of 0 and the full dividend as the remainder. A comparison made without the carry bit gets this wrong when the top operand bit is set.
- Equal operands and a dividend with only the top bit set, where a wrong comparison shows up as a missing or extra quotient bit.
- Zero divisors, including zero divided by zero. The quotient must be all ones, and a design that ends the divide early would also show a shortened busy window.

Starts raised during an active divide and during the done cycle would disturb the latency or the operands of a design that fails to ignore them. Held-high starts exercise the back-to-back path.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    DV_IDLE  = 2'd0,
    DV_SETUP = 2'd1,
    DV_ITER  = 2'd2,
    DV_WB    = 2'd3
  } dv_state_e;

  function automatic int unsigned div_latency(input int unsigned setup_cyc,
                                              input int unsigned width);
    return setup_cyc + width + 1;
  endfunction

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter int unsigned SETUP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic check_o,
  output logic load_o,
  output logic step_o,
  output logic last_step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned MAXC = (WIDTH > SETUP_CYCLES) ? WIDTH : SETUP_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned LAT  = div_latency(SETUP_CYCLES, WIDTH);
  localparam int unsigned LW   = $clog2(LAT + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYCLES - 1);
  localparam logic [CW-1:0] ITER_LAST  = CW'(WIDTH - 1);

  dv_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        DV_IDLE: begin
          if (start_i) begin
            state_q <= DV_SETUP;
            cnt_q   <= '0;
          end
        end
        DV_SETUP: begin
          if (cnt_q == SETUP_LAST) begin
            state_q <= DV_ITER;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        DV_ITER: begin
          if (cnt_q == ITER_LAST) begin
            state_q <= DV_WB;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= DV_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    accept_o    = (state_q == DV_IDLE) && start_i;
    check_o     = (state_q == DV_SETUP) && (cnt_q == '0);
    load_o      = (state_q == DV_SETUP) && (cnt_q == SETUP_LAST);
    step_o      = (state_q == DV_ITER);
    last_step_o = (state_q == DV_ITER) && (cnt_q == ITER_LAST);
    busy_o      = (state_q != DV_IDLE);
    done_o      = (state_q == DV_WB);
  end

  // checker-only busy-cycle counter
  logic [LW-1:0] lat_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_cnt_q <= '0;
    else if (busy_o) lat_cnt_q <= lat_cnt_q + 1'b1;
    else             lat_cnt_q <= '0;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt_q == LW'(LAT - 1))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R3
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o); // R8

endmodule

// File: rtl/div_operand_stage.sv
module div_operand_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             check_i,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] dvd_o,
  output logic [WIDTH-1:0] dvsr_o,
  output logic             zero_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_o  <= '0;
      dvsr_o <= '0;
    end else if (accept_i) begin
      dvd_o  <= dividend_i;
      dvsr_o <= divisor_i;
    end
  end

  // first setup cycle: register the zero-divisor flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zero_o <= 1'b0;
    else if (check_i) zero_o <= (dvsr_o == '0);
  end

  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i) |=> ($stable(dvd_o) && $stable(dvsr_o))); // R6

endmodule

// File: rtl/div_iter_unit.sv
module div_iter_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_step_i,
  input  logic             zero_i,
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dvsr_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);

  logic [WIDTH-1:0] prem_q;
  logic [WIDTH-1:0] qsh_q;
  logic [WIDTH:0]   trial;
  logic [WIDTH:0]   diff;
  logic             fits;
  logic [WIDTH-1:0] prem_nxt;
  logic [WIDTH-1:0] qsh_nxt;

  always_comb begin
    trial    = {prem_q, qsh_q[WIDTH-1]};
    diff     = trial - {1'b0, dvsr_i};
    fits     = (trial >= {1'b0, dvsr_i});
    prem_nxt = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    qsh_nxt  = {qsh_q[WIDTH-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prem_q <= '0;
      qsh_q  <= '0;
    end else if (load_i) begin
      prem_q <= '0;
      qsh_q  <= dvd_i;
    end else if (step_i) begin
      prem_q <= prem_nxt;
      qsh_q  <= qsh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_o <= '0;
      rem_o <= '0;
    end else if (last_step_i) begin
      quo_o <= zero_i ? '1    : qsh_nxt;
      rem_o <= zero_i ? dvd_i : prem_nxt;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_step_i |=> ($stable(quo_o) && $stable(rem_o))); // R5
  AST_PREM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !zero_i) |=> (prem_q < dvsr_i)); // R4

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter int unsigned SETUP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);

  logic             accept_w, check_w, load_w, step_w, last_w, zero_w;
  logic [WIDTH-1:0] dvd_w, dvsr_w;

  div_ctrl #(.WIDTH(WIDTH), .SETUP_CYCLES(SETUP_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept_w), .check_o(check_w), .load_o(load_w),
    .step_o(step_w), .last_step_o(last_w),
    .busy_o(busy_o), .done_o(done_o)
  );

  div_operand_stage #(.WIDTH(WIDTH)) u_opnd (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .check_i(check_w),
    .busy_i(busy_o), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .dvd_o(dvd_w), .dvsr_o(dvsr_w), .zero_o(zero_w)
  );

  div_iter_unit #(.WIDTH(WIDTH)) u_iter (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
    .last_step_i(last_w), .zero_i(zero_w),
    .dvd_i(dvd_w), .dvsr_i(dvsr_w),
    .quo_o(quotient_o), .rem_o(remainder_o)
  );

  AST_ZERO_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && zero_w) |-> ((quotient_o == '1) && (remainder_o == dvd_w))); // R7
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !zero_w) |-> (remainder_o < dvsr_w)); // R4
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R3

endmodule

// File: tb/iter_divider_tb.sv
`timescale 1ns/1ps
module iter_divider_tb;

  localparam int W   = 32;
  localparam int LAT = 35;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         busy, done;
  logic [W-1:0] quo, rem;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string tag = "R4";

  int           m_left = 0;
  logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;

  always #4 clk = ~clk;

  iter_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .dividend_i(a_in), .divisor_i(b_in),
    .busy_o(busy), .done_o(done), .quotient_o(quo), .remainder_o(rem)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_q = '0; m_r = '0;
    end else if (m_left == 0) begin
      if (start) begin
        m_left = LAT;
        p_q = (b_in == 0) ? '1 : a_in / b_in;
        p_r = (b_in == 0) ? a_in : a_in % b_in;
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 1) begin m_q = p_q; m_r = p_r; end
    end
  end

  task automatic chk(input string r, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "busy", W'(busy), W'(m_left > 0));
      chk("R3", "done", W'(done), W'(m_left == 1));
      chk(tag, "quotient", quo, m_q);
      chk(tag, "remainder", rem, m_r);
    end
  end

  task automatic wait_idle();
    while (m_left != 0) @(negedge clk);
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string t);
    wait_idle();
    tag = t; a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", W'(busy), '0);
    chk("R1", "reset done", W'(done), '0);
    chk("R1", "reset quotient", quo, '0);
    chk("R1", "reset remainder", rem, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'd100, 32'd7, "R4");
    run(32'hFFFF_FFFF, 32'd1, "R4");
    run(32'd5, 32'hFFFF_FFFF, "R4");
    run(32'h8000_0000, 32'hFFFF_FFFF, "R4");
    run(32'h1234_5678, 32'h1234_5678, "R4");
    run(32'h8000_0000, 32'd3, "R4");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    run(32'd12345678, 32'h0001_0000, "R5");
    run(32'hDEAD_BEEF, 32'd0, "R7");
    run(32'd0, 32'd0, "R7");
    run(32'd0, 32'd9, "R4");

    // R6: starts during an active divide and during the done cycle
    wait_idle();
    tag = "R6"; a_in = 32'd1000; b_in = 32'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    a_in = 32'd77; b_in = 32'd0; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0; a_in = 32'd1000; b_in = 32'd10;
    while (m_left != 1) @(negedge clk);
    a_in = 32'd55; b_in = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);

    // R8: start held high across done gives back-to-back divides
    tag = "R8"; a_in = 32'd999; b_in = 32'd4; start = 1'b1;
    @(negedge clk);
    a_in = 32'd500; b_in = 32'd6;
    while (m_left != 1) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);

    lf = 32'hACE1_2345;
    for (int i = 0; i < 6; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(lf, lf >> (i * 5), "R4");
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule